// File: doc/BRIEF.md
# Scoreboard Control Unit

This block is the hazard-tracking controller of a dynamically scheduled pipeline. Each cycle it is offered at most one decoded instruction: an operation code, the class of functional unit it needs, a destination register and two source registers. The instruction is accepted in program order. After that, each instruction moves on its own through operand read, execution and result write-back. There is no bypass path. Read-after-write dependences are resolved by waiting for the producer to write back. Write-after-write conflicts stall issue. Write-after-read conflicts hold a finished unit back from writing.

Each functional unit has one status entry. The entry holds a busy stage, the operation, the destination and source register numbers, the producing unit of each source, and a ready flag per source. A result map with one slot per register names the unit that will write that register. The surrounding datapath uses three signals from the controller:

- a per-unit operand-read grant, which carries the register numbers to fetch;
- a per-unit completion pulse, which the datapath sends back when execution ends;
- a per-unit write-back grant, which carries the register to write.

Top module: `sb_scoreboard`

## Requirements
- R1: After reset every unit is idle, no read or write-back grant is raised, and the first valid instruction is accepted.
- R2: `issue_accept` is high in the same cycle as `in_valid` when an idle unit of the requested class exists and the destination is not pending. The lowest-numbered idle unit of that class is chosen and reported on `issue_fu`. In the default build, class 0 is unit 0 (integer/load), class 1 is units 1 and 2 (multiply), class 2 is unit 3 (add) and class 3 is unit 4 (divide).
- R3: Issue stalls while every unit of the requested class is busy, even when units of other classes are idle.
- R4: Issue stalls while the destination register is the pending target of an issued, unwritten instruction. A write-back of that register granted in the same cycle is applied first, so the new instruction is accepted and becomes the new pending writer.
- R5: An instruction whose sources are both ready raises `rd_grant` for its unit in the cycle after issue. In that cycle, `rd_op`, `rd_src1` and `rd_src2` for the unit carry its operation and source register numbers.
- R6: An instruction with a source pending on another unit gets no read grant until that producer writes back. Its read grant comes in the cycle after the producer's write-back grant.
- R7: A completion pulse counts only while the unit is executing, which means after its read grant. A pulse at any other time is ignored. A counted pulse leads to a write-back grant in the next cycle unless R8 holds it.
- R8: A unit whose execution has finished does not write back while another unit that has not yet read its operands has a ready source equal to the finished unit's destination. It writes back in the cycle after that reader's read grant.
- R9: A write-back grant frees the unit and the destination's slot in the result map. `wb_dst` carries the destination register, and the unit can be issued to again from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A decoded instruction is offered |
| in_op | input | OP_W | Operation code |
| in_class | input | CLS_W | Required functional-unit class |
| in_dst | input | log2(NUM_REG) | Destination register |
| in_src1 | input | log2(NUM_REG) | First source register |
| in_src2 | input | log2(NUM_REG) | Second source register |
| fu_done | input | NUM_FU | Per-unit execution-complete pulse |
| issue_accept | output | 1 | Offered instruction is taken this cycle |
| issue_fu | output | log2(NUM_FU) | Unit chosen for the accepted instruction |
| rd_grant | output | NUM_FU | Per-unit operand-read grant (registered) |
| rd_op | output | NUM_FU*OP_W | Operation for each granted read |
| rd_src1 | output | NUM_FU*log2(NUM_REG) | First source register per unit |
| rd_src2 | output | NUM_FU*log2(NUM_REG) | Second source register per unit |
| wb_grant | output | NUM_FU | Per-unit write-back grant (registered) |
| wb_dst | output | NUM_FU*log2(NUM_REG) | Destination register per write-back |

## Verification
The bench uses the default parameters: five units in four classes, and 32 registers. Because units 1 and 2 share the multiply class, the bench can show the lowest-index choice inside a class and a class-wide structural stall while another class has an idle unit. The single-unit add and divide classes make the write-after-write stall and the write-back-first ordering easy to set up. A divider left waiting on a multiplier's result serves as the stalled reader that holds back an adder's write-back in the write-after-read case.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_OPS = 2'd1,
    ST_EXEC     = 2'd2,
    ST_WB_WAIT  = 2'd3
  } sb_stage_e;
endpackage

// File: rtl/sb_fu_entry.sv
module sb_fu_entry
  import sb_pkg::*;
#(
  parameter int NUM_FU = 5,
  parameter int OP_W   = 4,
  parameter int RW     = 5,
  parameter int FUW    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_we,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [RW-1:0]     iss_fi,
  input  logic [RW-1:0]     iss_fj,
  input  logic [RW-1:0]     iss_fk,
  input  logic [FUW-1:0]    iss_qj,
  input  logic              iss_qjv,
  input  logic [FUW-1:0]    iss_qk,
  input  logic              iss_qkv,
  input  logic              rd_go,
  input  logic              wb_go,
  input  logic              done_in,
  input  logic [NUM_FU-1:0] wb_vec,
  output sb_stage_e         stage,
  output logic [OP_W-1:0]   op,
  output logic [RW-1:0]     fi,
  output logic [RW-1:0]     fj,
  output logic [RW-1:0]     fk,
  output logic              rj,
  output logic              rk
);
  logic [FUW-1:0] qj, qk;
  logic           qjv, qkv;

  // true when the named producer is granted write-back this cycle
  function automatic logic producer_writes(input logic [FUW-1:0] q,
                                           input logic [NUM_FU-1:0] v);
    logic hit;
    hit = 1'b0;
    for (int f = 0; f < NUM_FU; f++)
      if (v[f] && q == f[FUW-1:0]) hit = 1'b1;
    return hit;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= ST_IDLE;
      op    <= '0;
      fi    <= '0;
      fj    <= '0;
      fk    <= '0;
      qj    <= '0;
      qk    <= '0;
      qjv   <= 1'b0;
      qkv   <= 1'b0;
      rj    <= 1'b0;
      rk    <= 1'b0;
    end else if (iss_we) begin
      stage <= ST_WAIT_OPS;
      op    <= iss_op;
      fi    <= iss_fi;
      fj    <= iss_fj;
      fk    <= iss_fk;
      qj    <= iss_qj;
      qk    <= iss_qk;
      qjv   <= iss_qjv;
      qkv   <= iss_qkv;
      rj    <= !iss_qjv;
      rk    <= !iss_qkv;
    end else begin
      unique case (stage)
        ST_WAIT_OPS: begin
          if (rd_go) begin
            stage <= ST_EXEC;
            rj    <= 1'b0;
            rk    <= 1'b0;
          end else begin
            if (qjv && producer_writes(qj, wb_vec)) begin
              qjv <= 1'b0;
              rj  <= 1'b1;
            end
            if (qkv && producer_writes(qk, wb_vec)) begin
              qkv <= 1'b0;
              rk  <= 1'b1;
            end
          end
        end
        ST_EXEC:     if (done_in) stage <= ST_WB_WAIT;
        ST_WB_WAIT:  if (wb_go) stage <= ST_IDLE;
        default: ;
      endcase
    end
  end

  a_r5_read_only_when_ready: assert property (@(posedge clk) disable iff (rst)
    (stage == ST_EXEC && $past(stage) == ST_WAIT_OPS) |-> $past(rj && rk));

  a_r7_done_ignored_before_read: assert property (@(posedge clk) disable iff (rst)
    (stage == ST_WAIT_OPS && done_in && !iss_we) |=> stage != ST_WB_WAIT);
endmodule

// File: rtl/sb_reg_status.sv
module sb_reg_status #(
  parameter int NUM_REG = 32,
  parameter int NUM_FU  = 5,
  parameter int RW      = 5,
  parameter int FUW     = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_en,
  input  logic [RW-1:0]      set_reg,
  input  logic [FUW-1:0]     set_fu,
  input  logic [NUM_FU-1:0]  wb_vec,
  input  logic [NUM_FU*RW-1:0] wb_dst_flat,
  input  logic [RW-1:0]      look_d,
  input  logic [RW-1:0]      look_a,
  input  logic [RW-1:0]      look_b,
  output logic               pend_d,
  output logic [FUW-1:0]     who_d,
  output logic               pend_a,
  output logic [FUW-1:0]     who_a,
  output logic               pend_b,
  output logic [FUW-1:0]     who_b
);
  logic           pend_q [NUM_REG];
  logic [FUW-1:0] who_q  [NUM_REG];
  logic           clr    [NUM_REG];

  always_comb begin
    for (int r = 0; r < NUM_REG; r++) begin
      clr[r] = 1'b0;
      for (int f = 0; f < NUM_FU; f++)
        if (wb_vec[f] && wb_dst_flat[f*RW +: RW] == r[RW-1:0]) clr[r] = 1'b1;
    end
  end

  // write-back clear first, then a same-cycle issue claims the slot
  always_ff @(posedge clk) begin
    for (int r = 0; r < NUM_REG; r++) begin
      if (rst) begin
        pend_q[r] <= 1'b0;
        who_q[r]  <= '0;
      end else if (set_en && set_reg == r[RW-1:0]) begin
        pend_q[r] <= 1'b1;
        who_q[r]  <= set_fu;
      end else if (clr[r]) begin
        pend_q[r] <= 1'b0;
      end
    end
  end

  assign pend_d = pend_q[look_d];
  assign who_d  = who_q[look_d];
  assign pend_a = pend_q[look_a];
  assign who_a  = who_q[look_a];
  assign pend_b = pend_q[look_b];
  assign who_b  = who_q[look_b];

  a_r4_single_pending_writer: assert property (@(posedge clk) disable iff (rst)
    set_en |-> (!pend_q[set_reg] || clr[set_reg]));
endmodule

// File: rtl/sb_issue_ctl.sv
module sb_issue_ctl #(
  parameter int NUM_FU = 5,
  parameter int CLS_W  = 2,
  parameter int FUW    = 3,
  parameter logic [NUM_FU*CLS_W-1:0] FU_CLASS = '0
) (
  input  logic              in_valid,
  input  logic [CLS_W-1:0]  in_class,
  input  logic [NUM_FU-1:0] busy,
  input  logic [NUM_FU-1:0] wb_vec,
  input  logic              pend_d,
  input  logic [FUW-1:0]    who_d,
  input  logic              pend_a,
  input  logic [FUW-1:0]    who_a,
  input  logic              pend_b,
  input  logic [FUW-1:0]    who_b,
  output logic              accept,
  output logic [FUW-1:0]    sel_fu,
  output logic [FUW-1:0]    qj,
  output logic              qjv,
  output logic [FUW-1:0]    qk,
  output logic              qkv
);
  logic free, waw;

  function automatic logic leaving(input logic [FUW-1:0] q,
                                   input logic [NUM_FU-1:0] v);
    logic hit;
    hit = 1'b0;
    for (int f = 0; f < NUM_FU; f++)
      if (v[f] && q == f[FUW-1:0]) hit = 1'b1;
    return hit;
  endfunction

  always_comb begin
    free   = 1'b0;
    sel_fu = '0;
    for (int f = NUM_FU - 1; f >= 0; f--) begin
      if (!busy[f] && FU_CLASS[f*CLS_W +: CLS_W] == in_class) begin
        free   = 1'b1;
        sel_fu = f[FUW-1:0];
      end
    end
    // pending state as seen after this cycle's write-backs
    waw    = pend_d && !leaving(who_d, wb_vec);
    qj     = who_a;
    qjv    = pend_a && !leaving(who_a, wb_vec);
    qk     = who_b;
    qkv    = pend_b && !leaving(who_b, wb_vec);
    accept = in_valid && free && !waw;
  end
endmodule

// File: rtl/sb_scoreboard.sv
module sb_scoreboard
  import sb_pkg::*;
#(
  parameter int NUM_FU  = 5,
  parameter int NUM_REG = 32,
  parameter int OP_W    = 4,
  parameter int CLS_W   = 2,
  parameter logic [NUM_FU*CLS_W-1:0] FU_CLASS = {2'd3, 2'd2, 2'd1, 2'd1, 2'd0},
  localparam int RW  = $clog2(NUM_REG),
  localparam int FUW = (NUM_FU > 1) ? $clog2(NUM_FU) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [OP_W-1:0]      in_op,
  input  logic [CLS_W-1:0]     in_class,
  input  logic [RW-1:0]        in_dst,
  input  logic [RW-1:0]        in_src1,
  input  logic [RW-1:0]        in_src2,
  input  logic [NUM_FU-1:0]    fu_done,
  output logic                 issue_accept,
  output logic [FUW-1:0]       issue_fu,
  output logic [NUM_FU-1:0]    rd_grant,
  output logic [NUM_FU*OP_W-1:0] rd_op,
  output logic [NUM_FU*RW-1:0] rd_src1,
  output logic [NUM_FU*RW-1:0] rd_src2,
  output logic [NUM_FU-1:0]    wb_grant,
  output logic [NUM_FU*RW-1:0] wb_dst
);
  sb_stage_e       st   [NUM_FU];
  logic [OP_W-1:0] op_a [NUM_FU];
  logic [RW-1:0]   fi_a [NUM_FU];
  logic [RW-1:0]   fj_a [NUM_FU];
  logic [RW-1:0]   fk_a [NUM_FU];
  logic            rj_a [NUM_FU];
  logic            rk_a [NUM_FU];

  logic [NUM_FU-1:0]    busy, rd_go, wb_go, war;
  logic [NUM_FU*RW-1:0] fi_flat;

  logic           pend_d, pend_a, pend_b;
  logic [FUW-1:0] who_d, who_a, who_b;
  logic [FUW-1:0] qj, qk;
  logic           qjv, qkv;

  sb_reg_status #(.NUM_REG(NUM_REG), .NUM_FU(NUM_FU), .RW(RW), .FUW(FUW)) u_rstat (
    .clk(clk), .rst(rst),
    .set_en(issue_accept), .set_reg(in_dst), .set_fu(issue_fu),
    .wb_vec(wb_go), .wb_dst_flat(fi_flat),
    .look_d(in_dst), .look_a(in_src1), .look_b(in_src2),
    .pend_d(pend_d), .who_d(who_d),
    .pend_a(pend_a), .who_a(who_a),
    .pend_b(pend_b), .who_b(who_b)
  );

  sb_issue_ctl #(.NUM_FU(NUM_FU), .CLS_W(CLS_W), .FUW(FUW), .FU_CLASS(FU_CLASS)) u_issue (
    .in_valid(in_valid), .in_class(in_class), .busy(busy), .wb_vec(wb_go),
    .pend_d(pend_d), .who_d(who_d),
    .pend_a(pend_a), .who_a(who_a),
    .pend_b(pend_b), .who_b(who_b),
    .accept(issue_accept), .sel_fu(issue_fu),
    .qj(qj), .qjv(qjv), .qk(qk), .qkv(qkv)
  );

  for (genvar f = 0; f < NUM_FU; f++) begin : g_fu
    sb_fu_entry #(.NUM_FU(NUM_FU), .OP_W(OP_W), .RW(RW), .FUW(FUW)) u_entry (
      .clk(clk), .rst(rst),
      .iss_we(issue_accept && issue_fu == FUW'(f)),
      .iss_op(in_op), .iss_fi(in_dst), .iss_fj(in_src1), .iss_fk(in_src2),
      .iss_qj(qj), .iss_qjv(qjv), .iss_qk(qk), .iss_qkv(qkv),
      .rd_go(rd_go[f]), .wb_go(wb_go[f]), .done_in(fu_done[f]), .wb_vec(wb_go),
      .stage(st[f]), .op(op_a[f]), .fi(fi_a[f]), .fj(fj_a[f]), .fk(fk_a[f]),
      .rj(rj_a[f]), .rk(rk_a[f])
    );

    assign busy[f]              = st[f] != ST_IDLE;
    assign rd_go[f]             = st[f] == ST_WAIT_OPS && rj_a[f] && rk_a[f];
    assign fi_flat[f*RW +: RW]  = fi_a[f];

    // an unread, ready source of another unit still needs the old value
    always_comb begin
      war[f] = 1'b0;
      for (int g = 0; g < NUM_FU; g++) begin
        if (g != f && st[g] == ST_WAIT_OPS &&
            ((rj_a[g] && fj_a[g] == fi_a[f]) || (rk_a[g] && fk_a[g] == fi_a[f])))
          war[f] = 1'b1;
      end
    end
    assign wb_go[f] = st[f] == ST_WB_WAIT && !war[f];

    always_ff @(posedge clk) begin
      if (rst) begin
        rd_grant[f]            <= 1'b0;
        wb_grant[f]            <= 1'b0;
        rd_op[f*OP_W +: OP_W]  <= '0;
        rd_src1[f*RW +: RW]    <= '0;
        rd_src2[f*RW +: RW]    <= '0;
        wb_dst[f*RW +: RW]     <= '0;
      end else begin
        rd_grant[f] <= rd_go[f];
        wb_grant[f] <= wb_go[f];
        if (rd_go[f]) begin
          rd_op[f*OP_W +: OP_W] <= op_a[f];
          rd_src1[f*RW +: RW]   <= fj_a[f];
          rd_src2[f*RW +: RW]   <= fk_a[f];
        end
        if (wb_go[f]) wb_dst[f*RW +: RW] <= fi_a[f];
      end
    end

    a_r9_wb_leaves_unit_idle: assert property (@(posedge clk) disable iff (rst)
      wb_grant[f] |-> st[f] == ST_IDLE);

    a_r8_read_and_write_apart: assert property (@(posedge clk) disable iff (rst)
      !(rd_grant[f] && wb_grant[f]));
  end
endmodule

// File: tb/sb_scoreboard_test.sv
`timescale 1ns/1ps
module sb_scoreboard_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [3:0]  in_op;
  logic [1:0]  in_class;
  logic [4:0]  in_dst, in_src1, in_src2;
  logic [4:0]  fu_done;
  logic        issue_accept;
  logic [2:0]  issue_fu;
  logic [4:0]  rd_grant, wb_grant;
  logic [19:0] rd_op;
  logic [24:0] rd_src1, rd_src2, wb_dst;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sb_scoreboard uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_class(in_class),
    .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2), .fu_done(fu_done),
    .issue_accept(issue_accept), .issue_fu(issue_fu),
    .rd_grant(rd_grant), .rd_op(rd_op), .rd_src1(rd_src1), .rd_src2(rd_src2),
    .wb_grant(wb_grant), .wb_dst(wb_dst)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic issue_one(input int cls, input int dst, input int s1, input int s2,
                           input int op, input bit exp_acc, input int exp_fu,
                           input string tag);
    in_valid = 1'b1;
    in_class = 2'(cls);
    in_dst   = 5'(dst);
    in_src1  = 5'(s1);
    in_src2  = 5'(s2);
    in_op    = 4'(op);
    #1;
    chk(issue_accept == exp_acc, tag, int'(issue_accept), int'(exp_acc));
    if (exp_acc) chk(issue_fu == 3'(exp_fu), tag, int'(issue_fu), exp_fu);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pulse_done(input logic [4:0] mask);
    fu_done = mask;
    @(negedge clk);
    fu_done = '0;
  endtask

  task automatic t_reset();
    chk(rd_grant == 0, "R1 no read grant after reset", int'(rd_grant), 0);
    chk(wb_grant == 0, "R1 no write grant after reset", int'(wb_grant), 0);
  endtask

  task automatic t_basic();
    issue_one(0, 1, 2, 3, 5, 1'b1, 0, "R1 first issue accepted");
    chk(rd_grant[0] == 1'b0, "R5 no read in issue cycle", int'(rd_grant[0]), 0);
    cyc();
    chk(rd_grant[0] == 1'b1, "R5 read grant after issue", int'(rd_grant[0]), 1);
    chk(rd_src1[4:0] == 5'd2, "R5 src1 index", int'(rd_src1[4:0]), 2);
    chk(rd_src2[4:0] == 5'd3, "R5 src2 index", int'(rd_src2[4:0]), 3);
    chk(rd_op[3:0] == 4'd5, "R5 op", int'(rd_op[3:0]), 5);
    pulse_done(5'b00001);
    chk(wb_grant[0] == 1'b0, "R7 no write in completion edge", int'(wb_grant[0]), 0);
    cyc();
    chk(wb_grant[0] == 1'b1, "R7 write grant after completion", int'(wb_grant[0]), 1);
    chk(wb_dst[4:0] == 5'd1, "R9 write dest", int'(wb_dst[4:0]), 1);
    cyc();
    chk(wb_grant == 0, "R9 single write pulse", int'(wb_grant), 0);
  endtask

  task automatic t_structural();
    issue_one(2, 4, 1, 1, 1, 1'b1, 3, "R2 add unit chosen");
    issue_one(2, 6, 1, 1, 1, 1'b0, 0, "R3 add class busy stalls");
    issue_one(1, 7, 1, 2, 2, 1'b1, 1, "R2 lowest multiplier chosen");
    issue_one(1, 8, 1, 2, 2, 1'b1, 2, "R2 second multiplier chosen");
    issue_one(1, 9, 1, 2, 2, 1'b0, 0, "R3 multiply class full stalls");
    pulse_done(5'b01110);
    cyc();
    chk(wb_grant == 5'b01110, "R9 parallel write-backs", int'(wb_grant), 14);
    issue_one(2, 4, 1, 1, 1, 1'b1, 3, "R9 freed add unit reissued");
    cyc();
    pulse_done(5'b01000);
    cyc();
    chk(wb_grant == 5'b01000, "R9 drain add", int'(wb_grant), 8);
  endtask

  task automatic t_waw();
    issue_one(2, 5, 1, 2, 0, 1'b1, 3, "R2 add for r5");
    issue_one(3, 5, 1, 2, 0, 1'b0, 0, "R4 waw stall while reading");
    fu_done = 5'b01000;
    issue_one(3, 5, 1, 2, 0, 1'b0, 0, "R4 waw stall at completion");
    fu_done = '0;
    issue_one(3, 5, 1, 2, 0, 1'b1, 4, "R4 write-back first then issue");
    chk(wb_grant[3] == 1'b1, "R9 add write-back r5", int'(wb_grant[3]), 1);
    issue_one(2, 5, 1, 2, 0, 1'b0, 0, "R4 new pending writer blocks");
    chk(rd_grant[4] == 1'b1, "R5 divider read", int'(rd_grant[4]), 1);
    pulse_done(5'b10000);
    cyc();
    chk(wb_grant[4] == 1'b1, "R9 divider write-back", int'(wb_grant[4]), 1);
  endtask

  task automatic t_raw();
    issue_one(1, 7, 1, 2, 3, 1'b1, 1, "R2 multiplier for r7");
    issue_one(2, 10, 7, 3, 4, 1'b1, 3, "R2 add consumer issue");
    chk(rd_grant[1] == 1'b1, "R5 producer reads", int'(rd_grant[1]), 1);
    for (int i = 0; i < 2; i++) begin
      cyc();
      chk(rd_grant[3] == 1'b0, "R6 consumer waits", int'(rd_grant[3]), 0);
    end
    pulse_done(5'b00010);
    cyc();
    chk(wb_grant[1] == 1'b1, "R6 producer writes", int'(wb_grant[1]), 1);
    chk(rd_grant[3] == 1'b0, "R6 no read with write", int'(rd_grant[3]), 0);
    cyc();
    chk(rd_grant[3] == 1'b1, "R6 read after write", int'(rd_grant[3]), 1);
    chk(rd_src1[19:15] == 5'd7, "R6 consumer src1", int'(rd_src1[19:15]), 7);
    pulse_done(5'b01000);
    cyc();
    chk(wb_grant[3] == 1'b1, "R9 consumer write", int'(wb_grant[3]), 1);
    chk(wb_dst[19:15] == 5'd10, "R9 consumer dest", int'(wb_dst[19:15]), 10);
  endtask

  task automatic t_war();
    issue_one(1, 9, 1, 2, 0, 1'b1, 1, "R2 multiplier for r9");
    issue_one(3, 10, 8, 9, 0, 1'b1, 4, "R2 divider reader of r8");
    issue_one(2, 8, 3, 4, 0, 1'b1, 3, "R2 add writer of r8");
    cyc();
    chk(rd_grant[3] == 1'b1, "R5 add reads", int'(rd_grant[3]), 1);
    pulse_done(5'b11000);
    for (int i = 0; i < 3; i++) begin
      cyc();
      chk(wb_grant[3] == 1'b0, "R8 write held by reader", int'(wb_grant[3]), 0);
    end
    pulse_done(5'b00010);
    cyc();
    chk(wb_grant[1] == 1'b1, "R6 multiplier writes r9", int'(wb_grant[1]), 1);
    chk(rd_grant[4] == 1'b0, "R6 divider not yet read", int'(rd_grant[4]), 0);
    chk(wb_grant[3] == 1'b0, "R8 still held", int'(wb_grant[3]), 0);
    cyc();
    chk(rd_grant[4] == 1'b1, "R6 divider reads", int'(rd_grant[4]), 1);
    chk(rd_src2[24:20] == 5'd9, "R5 divider src2", int'(rd_src2[24:20]), 9);
    chk(wb_grant[3] == 1'b0, "R8 held during read", int'(wb_grant[3]), 0);
    cyc();
    chk(wb_grant[3] == 1'b1, "R8 write after reader", int'(wb_grant[3]), 1);
    chk(wb_dst[19:15] == 5'd8, "R8 write dest", int'(wb_dst[19:15]), 8);
    for (int i = 0; i < 2; i++) begin
      cyc();
      chk(wb_grant[4] == 1'b0, "R7 early completion ignored", int'(wb_grant[4]), 0);
    end
    pulse_done(5'b10000);
    cyc();
    chk(wb_grant[4] == 1'b1, "R7 divider writes", int'(wb_grant[4]), 1);
    chk(wb_dst[24:20] == 5'd10, "R9 divider dest", int'(wb_dst[24:20]), 10);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    in_valid = 1'b0;
    in_op = '0;
    in_class = '0;
    in_dst = '0;
    in_src1 = '0;
    in_src2 = '0;
    fu_done = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_structural();
    t_waw();
    t_raw();
    t_war();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule